// File: doc/BRIEF.md
# Segment LCD Display Buffer Controller

This block keeps the pixel data of a multiplexed segment LCD and chooses, for every common time slot, which segments are energized. Software edits a user buffer through a plain write port (common row, data word, per-bit mask) whenever it likes. When a common slot begins, the row belonging to the incoming common is copied from the user buffer into a separate frame buffer. The frame buffer feeds the panel, so a half-finished software update never appears partway through a slot.

A mode selector is applied between the buffers and the segment outputs. The modes are forced dark, forced lit, complemented, two blinking variants, and an alternation between the user and frame buffers. None of the modes alters either buffer. Two timing strobes from outside drive the block. `slot_tick` steps the common sequencer. `blink_tick` flips the blink phase used by the alternating modes. Analog drive levels and the bus protocol belong to neighbouring blocks.

Top module: `lcd_disp_ctrl`

## Requirements
- R1: During and directly after reset, `com_idx` is 0, both buffers are all zero, the blink phase is 0, and `seg_on` is all zero in the normal mode.
- R2: Each cycle with `slot_tick` high moves `com_idx` to `(com_idx+1) mod N_COM`. A cycle without it leaves `com_idx` unchanged.
- R3: On a `slot_tick` edge, the frame row of the common being entered is loaded from that common's user row. A write that has no tick does not change the frame buffer.
- R4: A write with `wr_en` high replaces only the bits of user row `wr_com` whose `wr_mask` bit is 1. All other bits and rows keep their values.
- R5: When a write and a latch target the same common in the same cycle, the frame row takes the user row as it was before the write, and the user row takes the new data.
- R6: In normal mode (`mode` = 0), `seg_on` equals the frame row of `com_idx`. A bit value of 1 means the segment is on.
- R7: In force-off mode (`mode` = 1), `seg_on` is all zero. The buffers are kept, so the stored pattern reappears on return to normal mode.
- R8: In force-on mode (`mode` = 2), `seg_on` is all ones.
- R9: In inverted mode (`mode` = 3), `seg_on` is the bitwise complement of the current frame row.
- R10: Each `blink_tick` flips the blink phase. In standard blink mode (`mode` = 4), `seg_on` shows the frame row in phase 0 and is all zero in phase 1.
- R11: In inverted blink mode (`mode` = 5), `seg_on` shows the complemented frame row in phase 0 and is all zero in phase 1.
- R12: In swap mode (`mode` = 6), `seg_on` shows the user row of `com_idx` in phase 0 and the frame row in phase 1.
- R13: The unused mode code 7 behaves like normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the user buffer |
| wr_com | input | CW | Common row to write |
| wr_data | input | N_SEG | New segment bits |
| wr_mask | input | N_SEG | Bits set to 1 are written |
| mode | input | 3 | Display mode code |
| slot_tick | input | 1 | Starts the next common slot |
| blink_tick | input | 1 | Flips the blink phase |
| com_idx | output | CW | Common currently driven |
| seg_on | output | N_SEG | Per-segment on/off for the current slot |

## Verification
The bench uses three commons so that the sequencer has to wrap at a count that is not a power of two. A counter that wrapped at 4 would show a fourth index and desynchronise every later row. The bench issues a write and a latch to the same row in one cycle. A design that let the new data pass straight into the frame buffer would then show the new pattern a full frame early. Single-bit masked writes are made to each bit in turn, and each result is read back through the swap mode; a mask applied inverted or ignored would change neighbouring bits. Every mode is swept over every common and both blink phases, followed by a return to normal. This catches swapped phase polarity, modes that destroy memory, and a reserved code that drives something other than the normal pattern.

// File: rtl/lcd_disp_pkg.sv
// Shared definitions for the segment LCD buffer controller.
package lcd_disp_pkg;

    // Display mode codes; the numeric values are the software-visible encoding.
    typedef enum logic [2:0] {
        DM_NORMAL    = 3'd0,
        DM_OFF       = 3'd1,
        DM_ON        = 3'd2,
        DM_INV       = 3'd3,
        DM_BLINK     = 3'd4,
        DM_BLINK_INV = 3'd5,
        DM_SWAP      = 3'd6,
        DM_RSVD      = 3'd7
    } disp_mode_e;

endpackage

// File: rtl/lcd_com_seq.sv
// Common sequencer and blink phase.
// Steps the active common modulo N_COM on each slot tick and flips the
// blink phase on each blink tick. Assumes the ticks are single-cycle strobes.
module lcd_com_seq #(
    parameter int N_COM = 4,
    parameter int CW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_tick,
    input  logic          blink_tick,
    output logic [CW-1:0] com_idx,
    output logic [CW-1:0] com_next,
    output logic          blink_phase
);

    localparam logic [CW-1:0] LAST = CW'(N_COM - 1);

    // Index of the common that the next slot tick enters.
    always_comb begin
        com_next = (com_idx == LAST) ? '0 : com_idx + CW'(1);
    end

    // Common counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)         com_idx <= '0;
        else if (slot_tick) com_idx <= com_next;
    end

    // Blink phase toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)          blink_phase <= 1'b0;
        else if (blink_tick) blink_phase <= ~blink_phase;
    end

endmodule

// File: rtl/lcd_row_store.sv
// User and frame buffers, one row per common.
// User rows take masked writes at any time. A frame row is loaded from its
// user row when latch_en names it; the value loaded is the one held before
// any write made in the same cycle. Out-of-range write rows are ignored.
module lcd_row_store #(
    parameter int N_COM = 4,
    parameter int N_SEG = 40,
    parameter int CW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_com,
    input  logic [N_SEG-1:0] wr_data,
    input  logic [N_SEG-1:0] wr_mask,
    input  logic             latch_en,
    input  logic [CW-1:0]    latch_com,
    input  logic [CW-1:0]    rd_com,
    output logic [N_SEG-1:0] user_row,
    output logic [N_SEG-1:0] frame_row
);

    logic [N_SEG-1:0] user_q  [N_COM];
    logic [N_SEG-1:0] frame_q [N_COM];

    for (genvar g = 0; g < N_COM; g++) begin : g_row
        // Masked write into this user row.
        always_ff @(posedge clk) begin
            if (!rst_n)
                user_q[g] <= '0;
            else if (wr_en && (wr_com == CW'(g)))
                user_q[g] <= (user_q[g] & ~wr_mask) | (wr_data & wr_mask);
        end

        // Copy of this row into the frame buffer at its slot start.
        always_ff @(posedge clk) begin
            if (!rst_n)
                frame_q[g] <= '0;
            else if (latch_en && (latch_com == CW'(g)))
                frame_q[g] <= user_q[g];
        end
    end

    // Read both buffers at the active common.
    always_comb begin
        user_row  = user_q[rd_com];
        frame_row = frame_q[rd_com];
    end

endmodule

// File: rtl/lcd_mode_mux.sv
// Output mode selection.
// Maps the stored rows, mode code and blink phase to the segment vector.
// Purely combinational; it never writes to the buffers.
module lcd_mode_mux
    import lcd_disp_pkg::*;
#(
    parameter int N_SEG = 40
) (
    input  logic [2:0]       mode,
    input  logic             blink_phase,
    input  logic [N_SEG-1:0] user_row,
    input  logic [N_SEG-1:0] frame_row,
    output logic [N_SEG-1:0] seg_on
);

    disp_mode_e mode_e;

    // Decode the mode and choose the pattern.
    always_comb begin
        mode_e = disp_mode_e'(mode);
        case (mode_e)
            DM_OFF:       seg_on = '0;
            DM_ON:        seg_on = '1;
            DM_INV:       seg_on = ~frame_row;
            DM_BLINK:     seg_on = blink_phase ? '0 : frame_row;
            DM_BLINK_INV: seg_on = blink_phase ? '0 : ~frame_row;
            DM_SWAP:      seg_on = blink_phase ? frame_row : user_row;
            default:      seg_on = frame_row;
        endcase
    end

endmodule

// File: rtl/lcd_disp_ctrl.sv
// Segment LCD display buffer controller, top level.
// Connects the sequencer, the row store and the mode mux. On each slot tick
// the row of the common being entered is copied from user to frame buffer.
// Assumes slot_tick and blink_tick are single-cycle strobes from a divider.
module lcd_disp_ctrl #(
    parameter int  N_COM = 4,
    parameter int  N_SEG = 40,
    localparam int CW    = (N_COM > 1) ? $clog2(N_COM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_com,
    input  logic [N_SEG-1:0] wr_data,
    input  logic [N_SEG-1:0] wr_mask,
    input  logic [2:0]       mode,
    input  logic             slot_tick,
    input  logic             blink_tick,
    output logic [CW-1:0]    com_idx,
    output logic [N_SEG-1:0] seg_on
);

    logic [CW-1:0]    com_next;
    logic             blink_phase;
    logic [N_SEG-1:0] user_row;
    logic [N_SEG-1:0] frame_row;

    lcd_com_seq #(.N_COM(N_COM), .CW(CW)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_tick   (slot_tick),
        .blink_tick  (blink_tick),
        .com_idx     (com_idx),
        .com_next    (com_next),
        .blink_phase (blink_phase)
    );

    lcd_row_store #(.N_COM(N_COM), .N_SEG(N_SEG), .CW(CW)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_com    (wr_com),
        .wr_data   (wr_data),
        .wr_mask   (wr_mask),
        .latch_en  (slot_tick),
        .latch_com (com_next),
        .rd_com    (com_idx),
        .user_row  (user_row),
        .frame_row (frame_row)
    );

    lcd_mode_mux #(.N_SEG(N_SEG)) mux_i (
        .mode        (mode),
        .blink_phase (blink_phase),
        .user_row    (user_row),
        .frame_row   (frame_row),
        .seg_on      (seg_on)
    );

endmodule

// File: rtl/lcd_disp_ctrl_chk.sv
// Property checker for lcd_disp_ctrl, attached by bind below.
module lcd_disp_ctrl_chk #(
    parameter int  N_COM = 4,
    parameter int  N_SEG = 40,
    localparam int CW    = (N_COM > 1) ? $clog2(N_COM) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode,
    input logic             slot_tick,
    input logic             blink_tick,
    input logic             blink_phase,
    input logic [CW-1:0]    com_idx,
    input logic [N_SEG-1:0] seg_on
);

    // R2
    com_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> com_idx == (($past(com_idx) == CW'(N_COM - 1)) ? CW'(0) : $past(com_idx) + CW'(1)));

    // R2
    com_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |=> $stable(com_idx));

    // R2
    com_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(com_idx) < N_COM);

    // R7
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd1) |-> (seg_on == '0));

    // R8
    force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2) |-> (seg_on == '1));

    // R10
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blink_tick |=> (blink_phase != $past(blink_phase)));

    // R10
    blink_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && blink_phase) |-> (seg_on == '0));

    // R11
    blink_inv_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && blink_phase) |-> (seg_on == '0));

endmodule

bind lcd_disp_ctrl lcd_disp_ctrl_chk #(.N_COM(N_COM), .N_SEG(N_SEG)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .slot_tick   (slot_tick),
    .blink_tick  (blink_tick),
    .blink_phase (blink_phase),
    .com_idx     (com_idx),
    .seg_on      (seg_on)
);

// File: tb/lcd_disp_ctrl_tb_top.sv
`timescale 1ns/1ps
module lcd_disp_ctrl_tb_top;

    localparam int NC = 3;
    localparam int NS = 8;
    localparam int CW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [CW-1:0] wr_com = '0;
    logic [NS-1:0] wr_data = '0;
    logic [NS-1:0] wr_mask = '0;
    logic [2:0]    mode = 3'd0;
    logic          slot_tick = 1'b0;
    logic          blink_tick = 1'b0;
    logic [CW-1:0] com_idx;
    logic [NS-1:0] seg_on;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model of the buffers, sequencer and phase
    logic [NS-1:0] mu [NC];
    logic [NS-1:0] mf [NC];
    int mc = 0;
    bit mph = 0;

    always #10 clk = ~clk;

    lcd_disp_ctrl #(.N_COM(NC), .N_SEG(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_com(wr_com),
        .wr_data(wr_data), .wr_mask(wr_mask), .mode(mode),
        .slot_tick(slot_tick), .blink_tick(blink_tick),
        .com_idx(com_idx), .seg_on(seg_on)
    );

    function automatic logic [NS-1:0] expect_seg(input logic [2:0] md);
        logic [NS-1:0] f, u;
        f = mf[mc];
        u = mu[mc];
        case (md)
            3'd1: return '0;
            3'd2: return '1;
            3'd3: return ~f;
            3'd4: return mph ? '0 : f;
            3'd5: return mph ? '0 : ~f;
            3'd6: return mph ? f : u;
            default: return f;
        endcase
    endfunction

    function automatic string mode_tag(input logic [2:0] md);
        case (md)
            3'd0: return "R6";
            3'd1: return "R7";
            3'd2: return "R8";
            3'd3: return "R9";
            3'd4: return "R10";
            3'd5: return "R11";
            3'd6: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update model after the rise, check at the next fall.
    task automatic cyc(input string tag, input bit we, input int wc, input logic [NS-1:0] wd,
                       input logic [NS-1:0] wm, input bit st, input bit bt, input logic [2:0] md);
        int nxt;
        wr_en = we; wr_com = CW'(wc); wr_data = wd; wr_mask = wm;
        slot_tick = st; blink_tick = bt; mode = md;
        @(posedge clk);
        #1;
        if (st) begin
            nxt = (mc + 1) % NC;
            mf[nxt] = mu[nxt];
            mc = nxt;
        end
        if (we) mu[wc] = (mu[wc] & ~wm) | (wd & wm);
        if (bt) mph = ~mph;
        @(negedge clk);
        compare({tag, " com"}, 32'(com_idx), 32'(mc));
        compare({tag, " seg"}, 32'(seg_on), 32'(expect_seg(md)));
        wr_en = 1'b0; slot_tick = 1'b0; blink_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int c = 0; c < NC; c++) begin mu[c] = '0; mf[c] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        compare("R1 com", 32'(com_idx), 32'd0);
        compare("R1 seg", 32'(seg_on), 32'd0);
        rst_n = 1'b1;
        cyc("R1 after release", 0, 0, '0, '0, 0, 0, 3'd0);

        // R3: writes without a tick leave the frame (output) dark
        for (int c = 0; c < NC; c++)
            cyc("R3 write no latch", 1, c, NS'(8'hA5 ^ (c * 8'h3C)), '1, 0, 0, 3'd0);

        // R2/R6: step through two frames
        for (int k = 0; k < 2 * NC; k++)
            cyc("R2 R6 step", 0, 0, '0, '0, 1, 0, 3'd0);
        cyc("R2 hold", 0, 0, '0, '0, 0, 0, 3'd0);

        // R4: single-bit masked writes to the current row, read via swap phase 0
        for (int b = 0; b < NS; b++)
            cyc("R4 bit write", 1, mc, ~mu[mc], NS'(1) << b, 0, 0, 3'd6);
        cyc("R4 nibble write", 1, mc, 8'hFF, 8'h0F, 0, 0, 3'd6);

        // R5: write and latch of the same row together
        cyc("R5 collide", 1, (mc + 1) % NC, 8'h5A, '1, 1, 0, 3'd0);
        cyc("R5 user new", 0, 0, '0, '0, 0, 0, 3'd6);
        for (int k = 0; k < NC; k++)
            cyc("R5 next frame", 0, 0, '0, '0, 1, 0, 3'd0);

        // Sweep modes x phases x commons
        for (int md = 0; md < 8; md++) begin
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c < NC; c++)
                    cyc(mode_tag(3'(md)), 0, 0, '0, '0, 1, 0, 3'(md));
                cyc("R10 phase flip", 0, 0, '0, '0, 0, 1, 3'(md));
            end
            if (md == 6) cyc("R12 write mid swap", 1, mc, 8'h3C, '1, 0, 0, 3'd6);
        end

        // R7: memory kept through forced modes
        cyc("R7 force off", 0, 0, '0, '0, 1, 0, 3'd1);
        cyc("R7 force on", 0, 0, '0, '0, 0, 0, 3'd2);
        cyc("R7 back to normal", 0, 0, '0, '0, 0, 0, 3'd0);

        done = 1;
        finish_run();
    end

endmodule